// File: doc/BRIEF.md
# Dual-Mode Event Timestamp and Watchdog Counter

A single 16-bit counter has two uses. A mode input selects which one is active. It advances only on clock cycles where a periodic tick enable is high, and the tick period is meant to be 250 µs. In binary mode it counts down without stopping from 0xFFFF and wraps from 0x0000 back to 0xFFFF, so one full turn spans 16384 ms.

Each incoming event strobe freezes the live count in a capture register. A source tag records which event class fired. Software subtracts a later stamp from an earlier one, modulo 65536, and multiplies by 250 µs to get the time between events. One wrap between the two events still gives the correct result.

In decimal mode the same register holds four BCD digits and works as a watchdog or general timer. It loads from a timer register and counts down with borrow across the digits. When it runs out it raises a sticky interrupt and reloads itself. A restart input reloads it early, which is how a watchdog is serviced.

Top module: `stamp_wdog_counter`

## Requirements
- R1: After reset, `count` is 0xFFFF, `irq` is 0, `cap_count` is 0x0000, `cap_src` is 0, and binary mode is assumed.
- R2: In binary mode (`bin_mode`=1), each cycle with `tick`=1 lowers `count` by one on that clock edge, and 0x0000 wraps to 0xFFFF.
- R3: On a cycle with `tick`=0, no load, no restart and no mode change, `count` keeps its value.
- R4: On any edge where `ev_stb` is non-zero, `cap_count` takes the `count` value present before that edge, and `cap_src` takes `ev_stb`. Bit 0 of `ev_stb` is a received control/indication channel event and bit 1 is a received monitor channel event. The elapsed ticks between two stamps are (earlier − later) mod 65536.
- R5: A cycle with `tmr_wr`=1 stores `tmr_wdata` in the timer register. In decimal mode it also loads `count` with that value on the same edge. In binary mode `count` is not affected.
- R6: In decimal mode (`bin_mode`=0), a tick on a count of 0x0002 or above performs a BCD decrement with borrow across the four digits (0x0010→0x0009, 0x1000→0x0999).
- R7: In decimal mode, a tick while `count` is 0x0001 or 0x0000 reloads `count` from the timer register and sets `irq`.
- R8: `irq` stays high until a cycle with `irq_clr`=1 clears it. An expiry on the same cycle as `irq_clr` leaves `irq` set.
- R9: In decimal mode, `wd_restart`=1 reloads `count` from the timer register. In binary mode it has no effect.
- R10: When `bin_mode` changes, `count` reloads on the next edge: to 0xFFFF when entering binary mode, or to the timer register value when entering decimal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 250 µs advance enable, one cycle wide |
| bin_mode | input | 1 | 1 = binary timestamp, 0 = BCD watchdog |
| tmr_wr | input | 1 | Timer register write strobe |
| tmr_wdata | input | 16 | Timer value, four BCD digits |
| wd_restart | input | 1 | Watchdog restart (decimal mode) |
| irq_clr | input | 1 | Clears the expiry interrupt |
| ev_stb | input | 2 | Event strobes: bit 0 control/indication rx, bit 1 monitor rx |
| count | output | 16 | Live counter value |
| cap_count | output | 16 | Count captured at the last event |
| cap_src | output | 2 | Strobe bits of the last event |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
The hardest case to reach from the ports is the binary wrap, which only happens after tens of thousands of ticks. It matters most when two event stamps straddle that wrap. The bench holds `tick` high for the long run until the count sits at 0x0002 and stamps an event there. It then crosses zero and stamps again at 0xFFFD, so the modulo difference is checked across the wrap. For the decimal side, timer values are chosen so that a single tick hits each borrow chain and the 0001-to-reload expiry.

// File: rtl/stamp_wdog_counter.sv
module stamp_wdog_counter #(
  parameter int DIGITS = 4,
  parameter int SRC_W  = 2,
  localparam int W     = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bin_mode,
  input  logic             tmr_wr,
  input  logic [W-1:0]     tmr_wdata,
  input  logic             wd_restart,
  input  logic             irq_clr,
  input  logic [SRC_W-1:0] ev_stb,
  output logic [W-1:0]     count,
  output logic [W-1:0]     cap_count,
  output logic [SRC_W-1:0] cap_src,
  output logic             irq
);

  logic         mode_q;
  logic [W-1:0] tmr_reg;
  logic         mode_chg, expire;

  function automatic logic [W-1:0] bcd_dec(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic         b;
    r = v;
    b = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (b) begin
        if (r[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = r[4*i +: 4] - 4'd1;
          b = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign mode_chg = (bin_mode != mode_q);
  assign expire   = !mode_chg && !bin_mode && !tmr_wr && !wd_restart && tick &&
                    (count == W'(0) || count == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b1;
      count   <= '1;
      tmr_reg <= '0;
    end else begin
      mode_q <= bin_mode;
      if (tmr_wr) tmr_reg <= tmr_wdata;
      if (mode_chg)                count <= bin_mode ? '1 : tmr_reg;
      else if (bin_mode) begin
        if (tick)                  count <= count - W'(1);
      end
      else if (tmr_wr)             count <= tmr_wdata;
      else if (wd_restart)         count <= tmr_reg;
      else if (expire)             count <= tmr_reg;
      else if (tick)               count <= bcd_dec(count);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_count <= '0;
      cap_src   <= '0;
    end else if (|ev_stb) begin
      cap_count <= count;
      cap_src   <= ev_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (expire)  irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  a_r2_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && bin_mode && mode_q) |=> count == $past(count) - W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && bin_mode == mode_q && !tmr_wr && !wd_restart) |=> $stable(count));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_stb) |=> (cap_count == $past(count) && cap_src == $past(ev_stb)));

  a_r7_expire_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bin_mode && !mode_q && !tmr_wr && !wd_restart &&
     (count == W'(0) || count == W'(1))) |=> irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r10_to_binary: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_mode && !mode_q) |=> count == '1);

endmodule

// File: tb/test_stamp_wdog_counter.sv
module test_stamp_wdog_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, bin_mode = 1'b1, tmr_wr = 1'b0, wd_restart = 1'b0, irq_clr = 1'b0;
  logic [15:0] tmr_wdata = '0;
  logic [1:0]  ev_stb = '0;
  logic [15:0] count, cap_count;
  logic [1:0]  cap_src;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] stamp_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  stamp_wdog_counter i_stamp_wdog_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .wd_restart(wd_restart), .irq_clr(irq_clr), .ev_stb(ev_stb),
    .count(count), .cap_count(cap_count), .cap_src(cap_src), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stamp(input logic [1:0] s);
    ev_stb = s;
    @(negedge clk);
    ev_stb = '0;
  endtask

  task automatic write_tmr(input logic [15:0] v);
    tmr_wr = 1'b1; tmr_wdata = v;
    @(negedge clk);
    tmr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 16'hFFFF);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 cap_count", cap_count, 16'h0000);
    chk("R1 cap_src", {14'd0, cap_src}, 16'd0);
  endtask

  task automatic t_binary_basic;
    ticks(3);
    chk("R2 three ticks", count, 16'hFFFC);
    idle(4);
    chk("R3 hold without tick", count, 16'hFFFC);
  endtask

  task automatic t_stamps;
    stamp(2'b01);
    chk("R4 stamp value", cap_count, 16'hFFFC);
    chk("R4 stamp source ci", {14'd0, cap_src}, 16'd1);
    stamp_a = cap_count;
    ticks(5);
    stamp(2'b10);
    chk("R4 stamp source mon", {14'd0, cap_src}, 16'd2);
    chk("R4 elapsed", stamp_a - cap_count, 16'd5);
  endtask

  task automatic t_wrap;
    ticks(16'hFFF7 - 16'h0002);
    chk("R2 reach 0002", count, 16'h0002);
    stamp(2'b11);
    chk("R4 stamp both", {14'd0, cap_src}, 16'd3);
    stamp_a = cap_count;
    ticks(2);
    chk("R2 reach zero", count, 16'h0000);
    ticks(1);
    chk("R2 wrap to FFFF", count, 16'hFFFF);
    ticks(2);
    stamp(2'b01);
    chk("R4 elapsed across wrap", stamp_a - cap_count, 16'd5);
  endtask

  task automatic t_binary_ignores;
    write_tmr(16'h0012);
    chk("R5 write ignored in binary", count, 16'hFFFD);
    wd_restart = 1'b1; @(negedge clk); wd_restart = 1'b0;
    chk("R9 restart ignored in binary", count, 16'hFFFD);
  endtask

  task automatic t_to_decimal;
    bin_mode = 1'b0;
    @(negedge clk);
    chk("R10 enter decimal loads timer", count, 16'h0012);
    ticks(2);
    chk("R6 bcd step", count, 16'h0010);
    ticks(1);
    chk("R6 borrow tens", count, 16'h0009);
    write_tmr(16'h1000);
    chk("R5 write loads in decimal", count, 16'h1000);
    ticks(1);
    chk("R6 borrow thousands", count, 16'h0999);
  endtask

  task automatic t_expiry;
    write_tmr(16'h0003);
    ticks(2);
    chk("R6 reach 0001", count, 16'h0001);
    chk("R8 irq low before expiry", {15'd0, irq}, 16'd0);
    ticks(1);
    chk("R7 reload on expiry", count, 16'h0003);
    chk("R7 irq set", {15'd0, irq}, 16'd1);
    idle(3);
    chk("R8 irq sticky", {15'd0, irq}, 16'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R8 irq cleared", {15'd0, irq}, 16'd0);
    write_tmr(16'h0001);
    tick = 1'b1; irq_clr = 1'b1; @(negedge clk); tick = 1'b0; irq_clr = 1'b0;
    chk("R8 set beats clear", {15'd0, irq}, 16'd1);
    chk("R7 reload from 0001", count, 16'h0001);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_restart;
    write_tmr(16'h0050);
    ticks(3);
    chk("R6 count 0047", count, 16'h0047);
    wd_restart = 1'b1; @(negedge clk); wd_restart = 1'b0;
    chk("R9 restart reloads", count, 16'h0050);
    chk("R9 no irq on restart", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_to_binary;
    bin_mode = 1'b1;
    @(negedge clk);
    chk("R10 enter binary", count, 16'hFFFF);
    ticks(1);
    chk("R2 binary resumes", count, 16'hFFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_binary_basic();
    t_stamps();
    t_wrap();
    t_binary_ignores();
    t_to_decimal();
    t_expiry();
    t_restart();
    t_to_binary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule